// File: doc/BRIEF.md
# Compact Directory Coherence Controller

This block is the home-side controller for an MSI coherence scheme shared by a set of private child caches. Children send it two kinds of traffic on one inbound port, which has two lanes. The request lane carries upgrade requests, where a child asks for S or M on a line. The response lane carries downgrade responses, where a child reports the state it has dropped to and, when it held the line dirty, the line itself. On one outbound port the controller sends upgrade grants and downgrade orders, each tagged with the child it is meant for.

The controller does not keep state for every address. It keeps a directory that shadows each child's cache rows, with one state and one tag per row. A child's state for a line is the stored state when the stored tag matches the line's tag, and I when it does not. Main memory is reached through a line-wide request/response handshake whose latency is not known in advance.

An upgrade request is first checked against every other child. For each child whose state conflicts with the request, the controller sends a downgrade order and then waits until the directory shows that the conflict is gone. After that it reads memory if the requester had nothing, and grants the new state.

Top module: `coh_home_ctrl`

## Requirements
- R1: After reset no outbound message and no memory request is pending, the request lane is ready, and every directory entry reads as I (state codes are I=0, S=1, M=2).
- R2: A directory entry whose stored tag differs from the address tag counts as I, so a request to the same row under another tag orders no downgrade from that child.
- R3: When both inbound lanes are valid in the same cycle, the response lane is consumed and the request lane is held off (request ready low).
- R4: A request for S orders every other child that holds M down to S and leaves children at S or I untouched.
- R5: A request for M orders every other child that is not at I down to I.
- R6: Each conflicting child receives exactly one downgrade order per upgrade request; a child with no conflict receives none.
- R7: A downgrade response that carries data causes a memory write of that line, and the directory records the state the child reported.
- R8: If the requester's directory state is I, exactly one memory read is issued and the grant (out_is_grant=1) carries the read data with out_has_data=1; if it is S, the grant is sent without data and no memory read is made.
- R9: An outbound message keeps its fields unchanged while out_ready is low, and a memory request keeps its fields unchanged while mem_req_ready is low.
- R10: A grant records the granted state and the line's tag for the requester, and later requests see that state.
- R11: Downgrade responses, including ones that carry data, are accepted while a memory read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upgrade request present |
| req_ready | output | 1 | Upgrade request taken this cycle |
| req_child | input | CID_W | Requesting child |
| req_addr | input | ADDR_W | Line address of the request |
| req_state | input | 2 | Wanted state (1=S, 2=M) |
| rsp_valid | input | 1 | Downgrade response present |
| rsp_ready | output | 1 | Downgrade response taken this cycle |
| rsp_child | input | CID_W | Responding child |
| rsp_addr | input | ADDR_W | Line address of the response |
| rsp_state | input | 2 | State the child now holds |
| rsp_has_data | input | 1 | Response carries a dirty line |
| rsp_data | input | LINE_W | Dirty line |
| out_valid | output | 1 | Outbound message present |
| out_ready | input | 1 | Outbound message accepted |
| out_is_grant | output | 1 | 1 = upgrade grant, 0 = downgrade order |
| out_child | output | CID_W | Target child |
| out_addr | output | ADDR_W | Line address |
| out_state | output | 2 | Granted state or state to drop to |
| out_has_data | output | 1 | Grant carries a line |
| out_data | output | LINE_W | Line for the grant |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Line address |
| mem_req_data | output | LINE_W | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | LINE_W | Read line |

## Verification
Two functions can fall in the same cycle. The first is taking a downgrade response, which may need the single memory request slot for a write-back. The second is the upgrade flow, which needs the same slot for its read and the same directory write port for its grant. The bench provokes this in three ways: it raises both inbound lanes together, it has a child write back a dirty line while a long-latency read is in flight, and it stalls the memory and outbound ports on fixed cyclic patterns so that these events pile up. The outcome is judged at the ports. The bench checks which lane was taken, checks that the write-back was accepted before the grant, and reads the written line back through a later grant to confirm that no write was lost or reordered behind the read.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    CS_I = 2'd0,
    CS_S = 2'd1,
    CS_M = 2'd2
  } coh_st_e;
endpackage

// File: rtl/coh_dir.sv
// Per-child shadow of the child cache rows: state (reset to I) plus tag.
module coh_dir
  import coh_pkg::*;
#(
  parameter int N_CHILD = 2,
  parameter int ROWS    = 16,
  parameter int TAG_W   = 12,
  parameter int CID_W   = 1,
  parameter int ROW_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [CID_W-1:0]          wr_child,
  input  logic [ROW_W-1:0]          wr_row,
  input  logic [1:0]                wr_st,
  input  logic [TAG_W-1:0]          wr_tag,
  input  logic [ROW_W-1:0]          q_row,
  input  logic [TAG_W-1:0]          q_tag,
  output logic [N_CHILD-1:0][1:0]   q_st
);
  for (genvar g = 0; g < N_CHILD; g++) begin : g_child
    logic [1:0]       st_q  [ROWS];
    logic [TAG_W-1:0] tag_m [ROWS];
    logic             hit;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int r = 0; r < ROWS; r++) st_q[r] <= CS_I;
      end else if (we && wr_child == CID_W'(g)) begin
        st_q[wr_row] <= wr_st;
      end
    end

    // tag store has no reset so it maps onto plain RAM
    always_ff @(posedge clk) begin
      if (we && wr_child == CID_W'(g)) tag_m[wr_row] <= wr_tag;
    end

    assign hit     = (st_q[q_row] != CS_I) && (tag_m[q_row] == q_tag);
    assign q_st[g] = hit ? st_q[q_row] : CS_I;
  end
endmodule

// File: rtl/coh_compat.sv
// Flags every child other than the requester whose state conflicts with the wanted state.
module coh_compat
  import coh_pkg::*;
#(
  parameter int N_CHILD = 2,
  parameter int CID_W   = 1
) (
  input  logic [1:0]               want,
  input  logic [CID_W-1:0]         req_child,
  input  logic [N_CHILD-1:0][1:0]  st,
  output logic [N_CHILD-1:0]       incompat
);
  for (genvar g = 0; g < N_CHILD; g++) begin : g_chk
    logic other;
    assign other       = (CID_W'(g) != req_child);
    assign incompat[g] = other && ((want == CS_M) ? (st[g] != CS_I) : (st[g] == CS_M));
  end
endmodule

// File: rtl/coh_home_ctrl.sv
module coh_home_ctrl
  import coh_pkg::*;
#(
  parameter int N_CHILD = 2,
  parameter int ROWS    = 16,
  parameter int ADDR_W  = 16,
  parameter int LINE_W  = 64,
  parameter int CID_W   = (N_CHILD > 1) ? $clog2(N_CHILD) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CID_W-1:0]  req_child,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_state,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [CID_W-1:0]  rsp_child,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [1:0]        rsp_state,
  input  logic              rsp_has_data,
  input  logic [LINE_W-1:0] rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_grant,
  output logic [CID_W-1:0]  out_child,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_state,
  output logic              out_has_data,
  output logic [LINE_W-1:0] out_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_req_data,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int TAG_W = ADDR_W - ROW_W;

  typedef enum logic [1:0] {F_IDLE, F_CHECK, F_MEMRD, F_SEND} fsm_e;

  fsm_e               fsm_q;
  logic [CID_W-1:0]   cur_child_q;
  logic [ADDR_W-1:0]  cur_addr_q;
  logic [1:0]         cur_want_q;
  logic [N_CHILD-1:0] wait_q;
  logic [LINE_W-1:0]  line_q;
  logic               line_ok_q;

  logic               ov_q, og_q, od_q;
  logic [CID_W-1:0]   oc_q;
  logic [ADDR_W-1:0]  oa_q;
  logic [1:0]         os_q;
  logic [LINE_W-1:0]  odata_q;

  logic               mv_q, mwe_q;
  logic [ADDR_W-1:0]  ma_q;
  logic [LINE_W-1:0]  mdata_q;

  logic [N_CHILD-1:0][1:0] dir_st;
  logic [N_CHILD-1:0]      incompat, need_dg;
  logic [CID_W-1:0]        dg_idx;
  logic                    slot_free, out_free, rsp_fire, req_fire, wr_issue;
  logic                    all_ok, dg_go, rd_go, grant_go, dir_we;
  logic [1:0]              req_st_now, dg_tgt;
  logic [CID_W-1:0]        dw_child;
  logic [ADDR_W-1:0]       dw_addr;
  logic [1:0]              dw_st;

  // handshake plumbing
  assign slot_free = !mv_q || mem_req_ready;
  assign out_free  = !ov_q || out_ready;
  assign rsp_ready = !rsp_has_data || slot_free;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign wr_issue  = rsp_fire && rsp_has_data;
  assign req_ready = (fsm_q == F_IDLE) && !rsp_valid;
  assign req_fire  = req_valid && req_ready;

  // directory: responses win the single write port, grants wait a cycle
  assign dir_we   = rsp_fire || grant_go;
  assign dw_child = rsp_fire ? rsp_child : cur_child_q;
  assign dw_addr  = rsp_fire ? rsp_addr  : cur_addr_q;
  assign dw_st    = rsp_fire ? rsp_state : cur_want_q;

  coh_dir #(
    .N_CHILD(N_CHILD), .ROWS(ROWS), .TAG_W(TAG_W), .CID_W(CID_W), .ROW_W(ROW_W)
  ) u_dir (
    .clk      (clk),
    .rst      (rst),
    .we       (dir_we),
    .wr_child (dw_child),
    .wr_row   (dw_addr[ROW_W-1:0]),
    .wr_st    (dw_st),
    .wr_tag   (dw_addr[ADDR_W-1:ROW_W]),
    .q_row    (cur_addr_q[ROW_W-1:0]),
    .q_tag    (cur_addr_q[ADDR_W-1:ROW_W]),
    .q_st     (dir_st)
  );

  coh_compat #(.N_CHILD(N_CHILD), .CID_W(CID_W)) u_compat (
    .want      (cur_want_q),
    .req_child (cur_child_q),
    .st        (dir_st),
    .incompat  (incompat)
  );

  assign need_dg    = incompat & ~wait_q;
  assign all_ok     = ~|incompat;
  assign req_st_now = dir_st[cur_child_q];
  assign dg_tgt     = (cur_want_q == CS_M) ? CS_I : CS_S;
  assign dg_go      = (fsm_q == F_CHECK) && (|need_dg) && out_free;
  assign rd_go      = (fsm_q == F_CHECK) && all_ok && (req_st_now == CS_I) && slot_free && !wr_issue;
  assign grant_go   = (fsm_q == F_SEND) && out_free && !rsp_fire;

  always_comb begin
    dg_idx = '0;
    for (int j = N_CHILD - 1; j >= 0; j--) begin
      if (need_dg[j]) dg_idx = CID_W'(j);
    end
  end

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q     <= F_IDLE;
      wait_q    <= '0;
      line_ok_q <= 1'b0;
    end else begin
      unique case (fsm_q)
        F_IDLE: if (req_fire) fsm_q <= F_CHECK;
        F_CHECK: begin
          if (dg_go) wait_q[dg_idx] <= 1'b1;
          if (all_ok) begin
            if (req_st_now == CS_I) begin
              if (rd_go) fsm_q <= F_MEMRD;
            end else begin
              line_ok_q <= 1'b0;
              fsm_q     <= F_SEND;
            end
          end
        end
        F_MEMRD: if (mem_rsp_valid) begin
          line_ok_q <= 1'b1;
          fsm_q     <= F_SEND;
        end
        F_SEND: if (grant_go) begin
          wait_q <= '0;
          fsm_q  <= F_IDLE;
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (req_fire) begin
      cur_child_q <= req_child;
      cur_addr_q  <= req_addr;
      cur_want_q  <= req_state;
    end
    if (fsm_q == F_MEMRD && mem_rsp_valid) line_q <= mem_rsp_data;
  end

  // outbound message register
  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= 1'b0;
    end else if (dg_go) begin
      ov_q <= 1'b1; og_q <= 1'b0; oc_q <= dg_idx; oa_q <= cur_addr_q;
      os_q <= dg_tgt; od_q <= 1'b0;
    end else if (grant_go) begin
      ov_q <= 1'b1; og_q <= 1'b1; oc_q <= cur_child_q; oa_q <= cur_addr_q;
      os_q <= cur_want_q; od_q <= line_ok_q; odata_q <= line_q;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  // memory request register: write-backs before reads
  always_ff @(posedge clk) begin
    if (rst) begin
      mv_q <= 1'b0;
    end else if (wr_issue) begin
      mv_q <= 1'b1; mwe_q <= 1'b1; ma_q <= rsp_addr; mdata_q <= rsp_data;
    end else if (rd_go) begin
      mv_q <= 1'b1; mwe_q <= 1'b0; ma_q <= cur_addr_q;
    end else if (mem_req_ready) begin
      mv_q <= 1'b0;
    end
  end

  assign out_valid     = ov_q;
  assign out_is_grant  = og_q;
  assign out_child     = oc_q;
  assign out_addr      = oa_q;
  assign out_state     = os_q;
  assign out_has_data  = od_q;
  assign out_data      = odata_q;
  assign mem_req_valid = mv_q;
  assign mem_req_we    = mwe_q;
  assign mem_req_addr  = ma_q;
  assign mem_req_data  = mdata_q;

  // ---------------- assertions ----------------
  logic [N_CHILD-1:0] oth_valid, oth_dirty;
  always_comb begin
    for (int g = 0; g < N_CHILD; g++) begin
      oth_valid[g] = (CID_W'(g) != cur_child_q) && (dir_st[g] != CS_I);
      oth_dirty[g] = (CID_W'(g) != cur_child_q) && (dir_st[g] == CS_M);
    end
  end

  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_is_grant) && $stable(out_child)
      && $stable(out_addr) && $stable(out_state) && $stable(out_has_data)));

  p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_addr)));

  p_excl_grant_r5: assert property (@(posedge clk) disable iff (rst)
    (grant_go && cur_want_q == CS_M) |-> ($countones(oth_valid) == 0));

  p_shared_grant_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_go && cur_want_q == CS_S) |-> ($countones(oth_dirty) == 0));

  p_data_grant_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_grant && $rose(out_valid) && out_has_data) |-> (out_state != CS_I));
endmodule

// File: tb/sim_coh_home_ctrl.sv
`timescale 1ns/100ps
module sim_coh_home_ctrl;
  localparam int NC = 2, RW = 16, AW = 8, LW = 32, CW = 1;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_ready;
  logic [CW-1:0] req_child = 0;
  logic [AW-1:0] req_addr = 0;
  logic [1:0]    req_state = 0;
  logic          rsp_valid = 0, rsp_ready;
  logic [CW-1:0] rsp_child = 0;
  logic [AW-1:0] rsp_addr = 0;
  logic [1:0]    rsp_state = 0;
  logic          rsp_has_data = 0;
  logic [LW-1:0] rsp_data = 0;
  logic          out_valid, out_ready = 1, out_is_grant, out_has_data;
  logic [CW-1:0] out_child;
  logic [AW-1:0] out_addr;
  logic [1:0]    out_state;
  logic [LW-1:0] out_data;
  logic          mem_req_valid, mem_req_ready = 1, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [LW-1:0] mem_req_data;
  logic          mem_rsp_valid = 0;
  logic [LW-1:0] mem_rsp_data = 0;

  coh_home_ctrl #(.N_CHILD(NC), .ROWS(RW), .ADDR_W(AW), .LINE_W(LW)) u0 (.*);

  int n_chk = 0, n_err = 0, cyc = 0, rd_cnt = 0, mem_lat = 2, wb_cnt = 0;
  logic [LW-1:0] mem_arr [256];
  logic [LW-1:0] exp_mem [256];
  int m_st [NC][RW];
  int m_tag[NC][RW];
  longint t_grant = 0, t_evict = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  function automatic int mlook(int c, int a);
    int r = a % RW;
    return (m_st[c][r] != 0 && m_tag[c][r] == a / RW) ? m_st[c][r] : 0;
  endfunction

  // memory model
  initial begin
    logic [LW-1:0] rd_data;
    int rd_pend, rd_tmr;
    rd_pend = 0; rd_tmr = 0; rd_data = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_req_ready = (cyc % 4 != 1);
      mem_rsp_valid = 0;
      if (rd_pend != 0) begin
        if (rd_tmr == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = rd_data; rd_pend = 0;
        end else rd_tmr--;
      end
      if (!rst && mem_req_valid && mem_req_ready) begin
        if (mem_req_we) mem_arr[mem_req_addr] = mem_req_data;
        else begin
          rd_cnt++; rd_pend = 1; rd_tmr = mem_lat; rd_data = mem_arr[mem_req_addr];
        end
      end
    end
  end

  // child sends a voluntary downgrade; returns cycles waited for acceptance
  task automatic evict(input int c, input int a, input int to, output int waited);
    int old = mlook(c, a);
    logic [LW-1:0] d = 32'hD000_0000 + LW'(wb_cnt * 512 + c * 256 + a);
    wb_cnt++;
    waited = 0;
    @(negedge clk);
    rsp_valid = 1; rsp_child = CW'(c); rsp_addr = AW'(a); rsp_state = 2'(to);
    rsp_has_data = (old == 2); rsp_data = d;
    #1;
    while (!rsp_ready) begin @(negedge clk); #1; waited++; end
    @(posedge clk); #1;
    rsp_valid = 0; rsp_has_data = 0;
    t_evict = $time;
    if (old == 2) exp_mem[a] = d;
    m_st[c][a % RW] = to;
    if (to == 0) m_st[c][a % RW] = 0;
  endtask

  task automatic do_req(input int c, input int a, input int want, input string tagr);
    int exp_dg[NC], dgc[NC], pend[NC];
    int exp_rd, done, rsp_on, rsp_acc, hold, tgt;
    logic [AW-1:0] h_a; logic [1:0] h_s; logic [CW-1:0] h_c; logic h_g;
    exp_rd = (mlook(c, a) == 0);
    tgt = (want == 2) ? 0 : 1;
    for (int j = 0; j < NC; j++) begin
      exp_dg[j] = (j != c) && ((want == 2) ? (mlook(j, a) != 0) : (mlook(j, a) == 2));
      dgc[j] = 0; pend[j] = -1;
    end
    rd_cnt = 0; done = 0; rsp_on = 0; rsp_acc = 0; hold = 0;
    h_a = 0; h_s = 0; h_c = 0; h_g = 0;
    @(negedge clk);
    req_valid = 1; req_child = CW'(c); req_addr = AW'(a); req_state = 2'(want);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
    for (int cy = 0; cy < 3000 && done == 0; cy++) begin
      @(negedge clk);
      if (rsp_on != 0 && rsp_acc != 0) begin rsp_valid = 0; rsp_on = 0; rsp_has_data = 0; end
      for (int j = 0; j < NC; j++) begin
        if (pend[j] > 0) pend[j]--;
        else if (pend[j] == 0 && rsp_on == 0) begin
          rsp_on = 1; pend[j] = -1;
          rsp_valid = 1; rsp_child = CW'(j); rsp_addr = AW'(a); rsp_state = 2'(tgt);
          rsp_has_data = (mlook(j, a) == 2);
          rsp_data = 32'hB000_0000 + LW'(wb_cnt * 512 + j * 256 + a);
          wb_cnt++;
          if (mlook(j, a) == 2) exp_mem[a] = rsp_data;
          m_st[j][a % RW] = tgt;
        end
      end
      out_ready = (cyc % 3 != 2);
      #1;
      rsp_acc = rsp_valid && rsp_ready;
      if (hold != 0) begin
        chk(out_valid && out_addr == h_a && out_state == h_s && out_child == h_c
            && out_is_grant == h_g, "R9 outbound hold", {out_addr, out_state}, {h_a, h_s});
        hold = 0;
      end
      if (out_valid && !out_ready) begin
        hold = 1; h_a = out_addr; h_s = out_state; h_c = out_child; h_g = out_is_grant;
      end
      if (out_valid && out_ready) begin
        if (!out_is_grant) begin
          chk(exp_dg[out_child] != 0 && out_addr == AW'(a),
              (want == 2) ? "R5 downgrade target child" : "R4 downgrade target child",
              out_child, c);
          chk(out_state == 2'(tgt), (want == 2) ? "R5 order to I" : "R4 order to S",
              out_state, tgt);
          dgc[out_child]++;
          pend[out_child] = 2;
        end else begin
          chk(out_child == CW'(c) && out_addr == AW'(a), "R10 grant target", out_child, c);
          chk(out_state == 2'(want), "R10 granted state", out_state, want);
          chk(out_has_data == exp_rd[0], "R8 grant data flag", out_has_data, exp_rd);
          if (exp_rd != 0) chk(out_data == exp_mem[a], "R7 R8 grant line", out_data, exp_mem[a]);
          t_grant = $time;
          done = 1;
        end
      end
    end
    rsp_valid = 0; rsp_has_data = 0;
    chk(done != 0, "R8 grant arrives", done, 1);
    for (int j = 0; j < NC; j++)
      chk(dgc[j] == exp_dg[j], {"R6 order count ", tagr}, dgc[j], exp_dg[j]);
    chk(rd_cnt == exp_rd, "R8 memory reads", rd_cnt, exp_rd);
    m_st[c][a % RW] = want;
    m_tag[c][a % RW] = a / RW;
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired act=0 exp=1");
    summary();
  end

  initial begin
    int w, c, a, want, cur, r;
    for (int k = 0; k < 256; k++) begin
      mem_arr[k] = LW'(k) * 32'h9E37_79B1 + 32'h1234;
      exp_mem[k] = mem_arr[k];
    end
    for (int j = 0; j < NC; j++)
      for (int k = 0; k < RW; k++) begin m_st[j][k] = 0; m_tag[j][k] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    chk(!out_valid, "R1 no outbound after reset", out_valid, 0);
    chk(!mem_req_valid, "R1 no memory request after reset", mem_req_valid, 0);
    chk(req_ready, "R1 request lane ready", req_ready, 1);

    // R1: fresh directory, nothing to downgrade
    do_req(0, 3, 2, "R1");
    do_req(1, 16 + 7, 1, "R1");

    // R2: same row, other tag held at M by child 0
    do_req(0, 16 * 1 + 5, 2, "R2");
    do_req(1, 16 * 2 + 5, 2, "R2");

    // sweep
    for (int it = 0; it < 240; it++) begin
      c = (it / 3) % 2;
      r = (it * 5) % RW;
      a = ((it / 16) % 3) * RW + r;
      want = (it % 2 != 0) ? 2 : 1;
      if (m_st[c][r] != 0 && m_tag[c][r] != a / RW)
        evict(c, m_tag[c][r] * RW + r, 0, w);
      cur = mlook(c, a);
      if (cur == 2) begin
        evict(c, a, (it % 4 == 1) ? 1 : 0, w);
        cur = mlook(c, a);
      end
      if (cur == 1 && want == 1) want = 2;
      do_req(c, a, want, "R4 R5");
    end

    // R3: both lanes valid together
    do_req(1, 40, 1, "R3");
    @(negedge clk);
    rsp_valid = 1; rsp_child = 1; rsp_addr = 40; rsp_state = 0; rsp_has_data = 0;
    req_valid = 1; req_child = 0; req_addr = 41; req_state = 1;
    #1;
    chk(rsp_ready && !req_ready, "R3 response lane first", {rsp_ready, req_ready}, 2'b10);
    @(posedge clk); #1;
    rsp_valid = 0; m_st[1][40 % RW] = 0;
    @(negedge clk); #1;
    chk(req_ready, "R3 request taken next", req_ready, 1);
    @(posedge clk); #1; req_valid = 0;
    repeat (30) @(negedge clk);
    m_st[0][41 % RW] = 1; m_tag[0][41 % RW] = 41 / RW;
    // R7: child 1 took 40 dirty then evicted, child 0 reads it back
    do_req(1, 40, 2, "R7");
    evict(1, 40, 0, w);
    do_req(0, 40, 1, "R7");

    // R11: dirty write-back while a slow read is outstanding
    mem_lat = 30;
    do_req(1, 16 * 3 + 9, 2, "R11");
    fork
      do_req(0, 16 * 4 + 2, 1, "R11");
      begin
        repeat (8) @(negedge clk);
        evict(1, 16 * 3 + 9, 0, w);
      end
    join
    chk(w <= 2, "R11 write-back accepted during read", w, 2);
    chk(t_evict < t_grant, "R11 accepted before grant", t_evict, t_grant);
    mem_lat = 2;
    do_req(0, 16 * 3 + 9, 2, "R11");

    repeat (5) @(negedge clk);
    summary();
  end
endmodule